// File: doc/BRIEF.md
# Multiplierless Symmetric Low-Pass FIR Filter

This block is a streaming twelve-tap low-pass FIR filter whose weights are all signed powers of two. It accepts one signed 12-bit sample on every clock and produces one filtered result on every clock. Because the impulse response is mirror-symmetric, the two samples that share a weight are summed first. Each of the six pair sums is then scaled by a fixed left shift, and the one negative weight is applied by subtracting its shifted term. The datapath therefore holds only adders, registers and wiring, and no multiplier.

The weights, from the newest sample to the oldest, are 2, 16, 8, -32, 16, 128, 128, 16, -32, 8, 16, 2. The shift amounts and the sign of each pair are build-time parameters. They are checked during elaboration against the output width. A single asynchronous active-high clear empties the sample history and the pipeline. A filter built with the default parameters has a DC gain of 276 and an absolute weight sum of 404. A 21-bit signed output is therefore enough to hold every full-scale input without overflow.

Top module: `fir_shift_add`

## Requirements
- R1: A single nonzero sample A, with zeros before and after it, produces the outputs A*2, A*16, A*8, A*-32, A*16, A*128, A*128, A*16, A*-32, A*8, A*16, A*2 on consecutive clocks, and zero after them.
- R2: The latency is exactly two rising edges. A sample on `x_in` at edge E first affects `y_out` just after edge E+1.
- R3: For any signed 12-bit input stream, `y_out` equals the sum over k = 0..11 of h[k]*x[n-k], with the weights h given above. A new result appears on every clock.
- R4: Inputs at both extremes (-2048 and 2047), in any arrangement, give the exact result with no wraparound on the 21-bit two's-complement output. The largest result, 827052, fits.
- R5: A constant input c that is held for at least 14 clocks gives `y_out` = 276*c.
- R6: While `clr` is high, `y_out` reads zero at once, with no clock edge needed. After `clr` is released, every sample taken before the clear is forgotten, so the output follows as if those samples had been zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one input sample and one output result per rising edge |
| clr | input | 1 | Asynchronous active-high clear of the sample history and the pipeline |
| x_in | input | 12 | Signed two's-complement input sample |
| y_out | output | 21 | Signed two's-complement filtered result |

## Verification
The bench drives impulses of both signs. A design that paired the wrong delay taps, or put the wrong sign on the -32 weight, would show a reordered or sign-flipped coefficient sequence. Impulses also catch an output that comes one clock early or late. Long constant runs at a moderate level and at the most negative code check the DC gain. Extreme-code streams, including the pattern that reaches the largest possible output, expose a pre-add or shifted term that is truncated or zero-extended instead of sign-extended. A clear asserted in the middle of a cycle with nonzero history must zero the output before the next edge. It must also leave no stale sample to come back later in the results.

// File: rtl/fir_sa_pkg.sv
package fir_sa_pkg;

   // Smallest signed width able to hold every value in -mag..+mag.
   function automatic int signed_bits_for(input longint mag);
      int n;
      n = 1;
      while ((longint'(1) <<< (n - 1)) <= mag) n++;
      return n;
   endfunction

endpackage

// File: rtl/fir_sa_delay_line.sv
module fir_sa_delay_line #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 11
) (
   input  logic                          clk,
   input  logic                          clr,
   input  logic [DATA_W-1:0]             din,
   output logic [DEPTH-1:0][DATA_W-1:0]  taps
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("fir_sa_delay_line: DEPTH must be at least 1");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or posedge clr) begin
            if (clr) taps[0] <= '0;
            else     taps[0] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or posedge clr) begin
            if (clr) taps[i] <= '0;
            else     taps[i] <= taps[i-1];
         end
      end
   end

   // Set once an edge has been taken out of clear, so $past is meaningful.
   logic past_ok;
   always_ff @(posedge clk or posedge clr) begin
      if (clr) past_ok <= 1'b0;
      else     past_ok <= 1'b1;
   end

   assert_dl_head_R3: assert property (@(posedge clk) disable iff (clr)
      past_ok |-> taps[0] == $past(din));

   for (genvar j = 1; j < DEPTH; j++) begin : g_chk
      assert_dl_shift_R3: assert property (@(posedge clk) disable iff (clr)
         past_ok |-> taps[j] == $past(taps[j-1]));
   end

endmodule

// File: rtl/fir_sa_pair_weight.sv
module fir_sa_pair_weight #(
   parameter int DATA_W = 12,
   parameter int OUT_W  = 21,
   parameter int SHIFT  = 0,
   parameter bit NEGATE = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [OUT_W-1:0]  term
);

   if (SHIFT < 0 || SHIFT + DATA_W + 1 > OUT_W) begin : g_bad_shift
      $error("fir_sa_pair_weight: SHIFT does not fit in OUT_W");
   end

   localparam int PRE_W = DATA_W + 1;

   logic [PRE_W-1:0] pre_sum;
   logic [OUT_W-1:0] pre_ext;
   logic [OUT_W-1:0] shifted;

   // Pre-add the mirrored samples at one extra bit of width.
   assign pre_sum = {a[DATA_W-1], a} + {b[DATA_W-1], b};
   // Sign-extend the pre-add sum to the output width before shifting.
   assign pre_ext = {{(OUT_W-PRE_W){pre_sum[PRE_W-1]}}, pre_sum};
   assign shifted = pre_ext << SHIFT;

   if (NEGATE) begin : g_sub
      assign term = '0 - shifted;
   end else begin : g_add
      assign term = shifted;
   end

endmodule

// File: rtl/fir_sa_sum_tree.sv
module fir_sa_sum_tree #(
   parameter int NTERMS = 6,
   parameter int OUT_W  = 21
) (
   input  logic                          clk,
   input  logic                          clr,
   input  logic [NTERMS-1:0][OUT_W-1:0]  terms,
   output logic [OUT_W-1:0]              y
);

   if (NTERMS < 1) begin : g_bad_terms
      $error("fir_sa_sum_tree: NTERMS must be at least 1");
   end

   logic [NTERMS-1:0][OUT_W-1:0] term_q;
   logic [OUT_W-1:0]             acc;

   // Stage 1: register the weighted pair terms.
   always_ff @(posedge clk or posedge clr) begin
      if (clr) term_q <= '0;
      else     term_q <= terms;
   end

   always_comb begin
      acc = '0;
      for (int i = 0; i < NTERMS; i++) acc = acc + term_q[i];
   end

   // Stage 2: register the total.
   always_ff @(posedge clk or posedge clr) begin
      if (clr) y <= '0;
      else     y <= acc;
   end

endmodule

// File: rtl/fir_shift_add.sv
module fir_shift_add #(
   parameter int               DATA_W              = 12,
   parameter int               NTAPS               = 12,
   parameter int               PAIR_SHIFT[NTAPS/2] = '{1, 4, 3, 5, 4, 7},
   parameter logic [NTAPS/2-1:0] PAIR_NEG          = 6'b001000,
   parameter int               OUT_W               = 21
) (
   input  logic                     clk,
   input  logic                     clr,
   input  logic signed [DATA_W-1:0] x_in,
   output logic signed [OUT_W-1:0]  y_out
);

   localparam int NPAIRS   = NTAPS / 2;
   localparam int DL_DEPTH = NTAPS - 1;

   function automatic longint weight_sum(input bit absolute);
      longint s;
      longint w;
      s = 0;
      for (int k = 0; k < NPAIRS; k++) begin
         w = longint'(1) <<< PAIR_SHIFT[k];
         if (PAIR_NEG[k] && !absolute) w = -w;
         s += 2 * w;
      end
      return s;
   endfunction

   localparam longint ABS_SUM = weight_sum(1'b1);
   localparam longint DC_GAIN = weight_sum(1'b0);
   localparam int     NEED_W  = fir_sa_pkg::signed_bits_for(ABS_SUM <<< (DATA_W - 1));

   if (NTAPS < 2 || (NTAPS % 2) != 0) begin : g_bad_taps
      $error("fir_shift_add: NTAPS must be even and at least 2");
   end
   if (OUT_W < NEED_W) begin : g_bad_width
      $error("fir_shift_add: OUT_W too small for worst-case output");
   end

   logic [DL_DEPTH-1:0][DATA_W-1:0] taps;
   logic [NTAPS-1:0][DATA_W-1:0]    win;
   logic [NPAIRS-1:0][OUT_W-1:0]    terms;
   logic [OUT_W-1:0]                y_raw;

   fir_sa_delay_line #(.DATA_W(DATA_W), .DEPTH(DL_DEPTH)) u_dl (
      .clk  (clk),
      .clr  (clr),
      .din  (x_in),
      .taps (taps)
   );

   // win[k] holds x[n-k]: the live input, then the delay line.
   assign win[0] = x_in;
   for (genvar k = 1; k < NTAPS; k++) begin : g_win
      assign win[k] = taps[k-1];
   end

   for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
      fir_sa_pair_weight #(
         .DATA_W (DATA_W),
         .OUT_W  (OUT_W),
         .SHIFT  (PAIR_SHIFT[p]),
         .NEGATE (PAIR_NEG[p])
      ) u_pw (
         .a    (win[p]),
         .b    (win[NTAPS-1-p]),
         .term (terms[p])
      );
   end

   fir_sa_sum_tree #(.NTERMS(NPAIRS), .OUT_W(OUT_W)) u_sum (
      .clk   (clk),
      .clr   (clr),
      .terms (terms),
      .y     (y_raw)
   );

   assign y_out = $signed(y_raw);

   // Run-length of an unchanging input, used to check the DC gain.
   localparam int RUN_LIM = NTAPS + 3;
   localparam int RUN_W   = $clog2(RUN_LIM + 1);
   logic [RUN_W-1:0] run_len;

   always_ff @(posedge clk or posedge clr) begin
      if (clr)                               run_len <= '0;
      else if (x_in != $signed(taps[0]))     run_len <= '0;
      else if (run_len != RUN_W'(RUN_LIM))   run_len <= run_len + 1'b1;
   end

   assert_dc_gain_R5: assert property (@(posedge clk) disable iff (clr)
      (run_len == RUN_W'(RUN_LIM) && x_in == $signed(taps[0]))
         |-> longint'(y_out) == longint'(x_in) * DC_GAIN);

   assert_clear_zero_R6: assert property (@(posedge clk)
      clr |-> y_out == '0);

endmodule

// File: tb/tb_fir_shift_add.sv
module tb_fir_shift_add;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic               clr;
   logic signed [11:0] x_in;
   logic signed [20:0] y_out;

   fir_shift_add dut (
      .clk   (clk),
      .clr   (clr),
      .x_in  (x_in),
      .y_out (y_out)
   );

   int          n_checks = 0;
   int          n_fail   = 0;
   int          hist[12];
   int          expq[$];
   bit          done     = 1'b0;
   int unsigned seed     = 32'h1234_5678;
   int          coef[12] = '{2, 16, 8, -32, 16, 128, 128, 16, -32, 8, 16, 2};

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      for (int k = 0; k < 12; k++) hist[k] = 0;
      expq = '{0, 0};
   endtask

   // One sample per clock: check the output due now, then drive a new input.
   task automatic step(input string req, input int x);
      int acc;
      @(negedge clk);
      check(req, int'(y_out), expq[0]);
      void'(expq.pop_front());
      x_in = 12'(x);
      for (int k = 11; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      acc = 0;
      for (int k = 0; k < 12; k++) acc += coef[k] * hist[k];
      expq.push_back(acc);
   endtask

   task automatic do_clear();
      @(negedge clk);
      x_in = '0;
      clr  = 1'b1;
      #1 check("R6 async", int'(y_out), 0);
      repeat (2) @(negedge clk);
      check("R6 held", int'(y_out), 0);
      clr = 1'b0;
      model_clear();
   endtask

   function automatic int rnd12();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 16) & 32'hFFF) - 2048;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R3 watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      clr  = 1'b1;
      x_in = '0;
      repeat (3) @(negedge clk);
      check("R6 reset", int'(y_out), 0);
      clr = 1'b0;
      model_clear();

      // R1 R2: unit impulse and a negative impulse.
      step("R1 R2 impulse", 1);
      for (int i = 0; i < 16; i++) step("R1 R2 impulse", 0);
      step("R1 negative impulse", -3);
      for (int i = 0; i < 16; i++) step("R1 negative impulse", 0);

      // R5: DC gain at a moderate level and at the most negative code.
      for (int i = 0; i < 20; i++) step("R5 dc", 100);
      @(negedge clk);
      check("R5 dc 100", int'(y_out), 100 * 276);
      for (int i = 0; i < 20; i++) step("R5 dc", -2048);
      @(negedge clk);
      check("R5 dc -2048", int'(y_out), -2048 * 276);
      for (int i = 0; i < 14; i++) step("R5 return", 0);

      // R4: largest positive output, then its negative, then random extremes.
      for (int j = 0; j < 12; j++) step("R4 peak", (coef[11-j] > 0) ? 2047 : -2048);
      step("R4 peak", 0);
      step("R4 peak", 0);
      check("R4 max value", int'(y_out), 827052);
      for (int j = 0; j < 12; j++) step("R4 trough", (coef[11-j] > 0) ? -2048 : 2047);
      for (int i = 0; i < 40; i++) step("R4 extremes", (rnd12() < 0) ? -2048 : 2047);

      // R3: general signed stream.
      for (int i = 0; i < 200; i++) step("R3 stream", rnd12());

      // R6: clear with live history, then confirm nothing stale returns.
      do_clear();
      for (int i = 0; i < 16; i++) step("R6 after clear", 0);
      step("R6 impulse after clear", 5);
      for (int i = 0; i < 14; i++) step("R6 impulse after clear", 0);

      // R3: another stream after the clear.
      for (int i = 0; i < 100; i++) step("R3 stream2", rnd12());

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule